// File: doc/BRIEF.md
# Multicycle Shared-Unit Processor Datapath

This block is the register-transfer half of a small 32-bit load/store processor that runs register arithmetic (add, subtract, and, or, set-less-than), word loads and stores, equality branches and absolute jumps. Each instruction is spread over several clock cycles. One adder/logic unit does all arithmetic: the next sequential PC, the branch target, the effective address and the return address saved on a trap. One memory port serves both instruction fetch and data access. Values that one step produces are held in internal registers and used in the next step.

The block makes no decisions of its own. An external sequencer drives every multiplexer select and every register write enable on each cycle. The block sends back the opcode and function fields of the held instruction, the ALU zero flag and a signed-overflow flag. The memory sits outside the block. It is read combinationally at the block's address output and written on a clock edge under the sequencer's control.

Top module: `multiCycleDatapath`

## Requirements
- R1: While reset is asserted, and right after it is released, the PC is 0, so `memAddr` shows 0 when `iorD`=0. `epcOut` and `causeOut` are also 0.
- R2: The instruction register loads `memRData` on a clock edge only while `irWrite`=1, and otherwise holds its value. `opcode` is instruction bits 31:26 and `funct` is bits 5:0.
- R3: `memAddr` is the PC when `iorD`=0 and the ALU result register when `iorD`=1. `memWData` is always the B operand register.
- R4: The first ALU operand is the PC when `aluSrcA`=0 and the A register when `aluSrcA`=1. The second operand is chosen by `aluSrcB`: 00 gives B, 01 gives the constant 4, 10 gives the sign-extended bits 15:0, and 11 gives that value shifted left by two.
- R5: `aluOp` 00 adds and 01 subtracts. With 10 the operation comes from `funct`: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x2A signed set-less-than, which gives 1 or 0. Code 11 also adds.
- R6: `aluOverflow` is 1 only when `aluOp`=10, `funct` is 0x20 or 0x22, and the signed result does not fit in 32 bits. `aluZero` is 1 exactly when the current ALU result is zero.
- R7: On every edge, A loads the register addressed by instruction bits 25:21, and B loads the register addressed by bits 20:16. MDR and the ALU result register also load on every edge. With `regWrite`=1, the register file writes at bits 15:11 when `regDst`=1 and at bits 20:16 when `regDst`=0. The data written is MDR when `memToReg`=1 and the ALU result register when `memToReg`=0.
- R8: Register 0 always reads as zero, and writes to it have no effect.
- R9: The PC updates when `pcWrite`=1, or when `pcWriteCond`=1 and `aluZero`=1. In every other cycle it holds.
- R10: `pcSource` picks the new PC: 00 the live ALU result, 01 the ALU result register, 10 the jump target {PC[31:28], instruction bits 25:0, 00}, 11 the fixed trap entry 0x80000180.
- R11: With `epcWrite`=1, EPC loads the live ALU result, which the sequencer sets up as PC-4. With `causeWrite`=1, Cause loads `intCause` zero-extended: 0 for an undefined instruction, 1 for an arithmetic overflow. Without its enable, each of the two holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| pcWrite | input | 1 | Unconditional PC update |
| pcWriteCond | input | 1 | PC update when the ALU result is zero |
| iorD | input | 1 | Memory address source: 0 PC, 1 ALU result register |
| irWrite | input | 1 | Load the instruction register from memory |
| regDst | input | 1 | Register write address: 1 bits 15:11, 0 bits 20:16 |
| memToReg | input | 1 | Register write data: 1 MDR, 0 ALU result register |
| regWrite | input | 1 | Register file write enable |
| aluSrcA | input | 1 | First ALU operand: 0 PC, 1 A |
| aluSrcB | input | 2 | Second ALU operand select |
| aluOp | input | 2 | ALU operation class |
| pcSource | input | 2 | New PC source select |
| epcWrite | input | 1 | Load EPC from the live ALU result |
| causeWrite | input | 1 | Load Cause from intCause |
| intCause | input | 1 | Trap reason: 0 undefined instruction, 1 overflow |
| memRData | input | 32 | Memory read data |
| memAddr | output | 32 | Memory address |
| memWData | output | 32 | Memory write data |
| opcode | output | 6 | Held instruction bits 31:26 |
| funct | output | 6 | Held instruction bits 5:0 |
| aluZero | output | 1 | ALU result is zero |
| aluOverflow | output | 1 | Signed overflow of a register add or subtract |
| epcOut | output | 32 | Saved trap return address |
| causeOut | output | 32 | Trap reason register |

## Verification
The trap step puts two functions in one cycle. The single ALU computes PC-4 into EPC while the PC is reloaded with the trap entry, on the same edge, and in the cycle just before that step the ALU had flagged an overflow. The bench provokes this by adding 0x7FFFFFFF and 1. It checks the overflow flag during the execute cycle, then raises `epcWrite`, `causeWrite` and `pcWrite` with source 11 together. After that edge it expects EPC to hold the address of the faulting instruction, Cause to hold 1 and the fetch address to be 0x80000180. This shows that the EPC path captured the old PC rather than the redirected one. Instruction fetch also has IR capture and PC+4 on one edge. Every fetch is therefore checked by comparing the next fetch address and the decoded fields with values computed in the bench.

// File: rtl/mcPkg.sv
`timescale 1ns/1ps
package mcPkg;
  localparam int WORD_W  = 32;
  localparam int REG_NUM = 32;
  localparam int REG_AW  = $clog2(REG_NUM);
  localparam int IMM_W   = 16;
  localparam int FN_W    = 6;
  localparam logic [WORD_W-1:0] RESET_PC   = '0;
  localparam logic [WORD_W-1:0] HANDLER_PC = 32'h8000_0180;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef enum logic [1:0] {
    SRCB_REG  = 2'b00,
    SRCB_FOUR = 2'b01,
    SRCB_IMM  = 2'b10,
    SRCB_IMM4 = 2'b11
  } srcB_e;

  typedef enum logic [1:0] {
    PCS_ALU    = 2'b00,
    PCS_ALUOUT = 2'b01,
    PCS_JUMP   = 2'b10,
    PCS_TRAP   = 2'b11
  } pcSrc_e;

  typedef enum logic [1:0] {
    AOP_ADD   = 2'b00,
    AOP_SUB   = 2'b01,
    AOP_FUNCT = 2'b10,
    AOP_RSVD  = 2'b11
  } aluOp_e;

  typedef enum logic [2:0] {
    FNC_ADD,
    FNC_SUB,
    FNC_AND,
    FNC_OR,
    FNC_SLT,
    FNC_NONE
  } aluFn_e;

  typedef struct packed {
    logic   pcWrite;
    logic   pcWriteCond;
    logic   iorD;
    logic   irWrite;
    logic   regDst;
    logic   memToReg;
    logic   regWrite;
    logic   aluSrcA;
    srcB_e  aluSrcB;
    aluOp_e aluOp;
    pcSrc_e pcSource;
    logic   epcWrite;
    logic   causeWrite;
    logic   intCause;
  } strobes_t;
endpackage

// File: rtl/mcAlu.sv
`timescale 1ns/1ps
module mcAlu
  import mcPkg::*;
(
  input  aluOp_e              op,
  input  logic [FN_W-1:0]     funct,
  input  logic [WORD_W-1:0]   a,
  input  logic [WORD_W-1:0]   b,
  output logic [WORD_W-1:0]   result,
  output logic                zero,
  output logic                overflow
);
  localparam int MSB = WORD_W - 1;

  aluFn_e fn;
  logic [WORD_W-1:0] sum;
  logic [WORD_W-1:0] diff;
  logic lessThan;
  logic ovfAdd;
  logic ovfSub;

  always_comb begin
    unique case (op)
      AOP_SUB: fn = FNC_SUB;
      AOP_FUNCT: begin
        unique case (funct)
          FN_ADD:  fn = FNC_ADD;
          FN_SUB:  fn = FNC_SUB;
          FN_AND:  fn = FNC_AND;
          FN_OR:   fn = FNC_OR;
          FN_SLT:  fn = FNC_SLT;
          default: fn = FNC_NONE;
        endcase
      end
      default: fn = FNC_ADD;
    endcase
  end

  assign sum      = a + b;
  assign diff     = a - b;
  assign lessThan = $signed(a) < $signed(b);
  assign ovfAdd   = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign ovfSub   = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

  always_comb begin
    unique case (fn)
      FNC_ADD: result = sum;
      FNC_SUB: result = diff;
      FNC_AND: result = a & b;
      FNC_OR:  result = a | b;
      FNC_SLT: result = {{(WORD_W-1){1'b0}}, lessThan};
      default: result = '0;
    endcase
  end

  assign zero     = (result == '0);
  assign overflow = (op == AOP_FUNCT) &&
                    (((fn == FNC_ADD) && ovfAdd) || ((fn == FNC_SUB) && ovfSub));
endmodule

// File: rtl/mcRegFile.sv
`timescale 1ns/1ps
module mcRegFile
  import mcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_AW-1:0] raddrA,
  input  logic [REG_AW-1:0] raddrB,
  input  logic [REG_AW-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              we,
  output logic [WORD_W-1:0] rdataA,
  output logic [WORD_W-1:0] rdataB
);
  logic [WORD_W-1:0] regQ [REG_NUM];

  for (genvar i = 0; i < REG_NUM; i++) begin : gReg
    if (i == 0) begin : gZero
      assign regQ[i] = '0;
    end else begin : gStore
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          regQ[i] <= '0;
        end else if (we && (waddr == REG_AW'(i))) begin
          regQ[i] <= wdata;
        end
      end
    end
  end

  assign rdataA = regQ[raddrA];
  assign rdataB = regQ[raddrB];
endmodule

// File: rtl/mcDpCore.sv
`timescale 1ns/1ps
module mcDpCore
  import mcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          s,
  input  logic [WORD_W-1:0] memRData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [FN_W-1:0]   opcode,
  output logic [FN_W-1:0]   funct,
  output logic              aluZero,
  output logic              aluOverflow,
  output logic [WORD_W-1:0] epcOut,
  output logic [WORD_W-1:0] causeOut
);
  logic [WORD_W-1:0] pcQ, irQ, mdrQ, aQ, bQ, aluOutQ, epcQ, causeQ;
  logic [WORD_W-1:0] rfA, rfB, rfWData;
  logic [REG_AW-1:0] rsF, rtF, rdF, rfWAddr;
  logic [WORD_W-1:0] immSext, immShift, opA, opB, aluRes, jumpTgt, pcNext;
  logic              pcLoad;

  // instruction fields
  assign rsF      = irQ[25:21];
  assign rtF      = irQ[20:16];
  assign rdF      = irQ[15:11];
  assign opcode   = irQ[31:26];
  assign funct    = irQ[FN_W-1:0];
  assign immSext  = {{(WORD_W-IMM_W){irQ[IMM_W-1]}}, irQ[IMM_W-1:0]};
  assign immShift = {immSext[WORD_W-3:0], 2'b00};
  assign jumpTgt  = {pcQ[WORD_W-1:WORD_W-4], irQ[25:0], 2'b00};

  // register file write port selection
  assign rfWAddr = s.regDst   ? rdF  : rtF;
  assign rfWData = s.memToReg ? mdrQ : aluOutQ;

  mcRegFile uRegs (
    .clk    (clk),
    .rstN   (rstN),
    .raddrA (rsF),
    .raddrB (rtF),
    .waddr  (rfWAddr),
    .wdata  (rfWData),
    .we     (s.regWrite),
    .rdataA (rfA),
    .rdataB (rfB)
  );

  // operand multiplexers
  assign opA = s.aluSrcA ? aQ : pcQ;
  always_comb begin
    unique case (s.aluSrcB)
      SRCB_REG:  opB = bQ;
      SRCB_FOUR: opB = WORD_W'(4);
      SRCB_IMM:  opB = immSext;
      default:   opB = immShift;
    endcase
  end

  mcAlu uAlu (
    .op       (s.aluOp),
    .funct    (funct),
    .a        (opA),
    .b        (opB),
    .result   (aluRes),
    .zero     (aluZero),
    .overflow (aluOverflow)
  );

  // next PC selection
  always_comb begin
    unique case (s.pcSource)
      PCS_ALU:    pcNext = aluRes;
      PCS_ALUOUT: pcNext = aluOutQ;
      PCS_JUMP:   pcNext = jumpTgt;
      default:    pcNext = HANDLER_PC;
    endcase
  end
  assign pcLoad = s.pcWrite || (s.pcWriteCond && aluZero);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pcQ     <= RESET_PC;
      irQ     <= '0;
      mdrQ    <= '0;
      aQ      <= '0;
      bQ      <= '0;
      aluOutQ <= '0;
      epcQ    <= '0;
      causeQ  <= '0;
    end else begin
      mdrQ    <= memRData;
      aQ      <= rfA;
      bQ      <= rfB;
      aluOutQ <= aluRes;
      if (s.irWrite)    irQ    <= memRData;
      if (pcLoad)       pcQ    <= pcNext;
      if (s.epcWrite)   epcQ   <= aluRes;
      if (s.causeWrite) causeQ <= WORD_W'(s.intCause);
    end
  end

  assign memAddr  = s.iorD ? aluOutQ : pcQ;
  assign memWData = bQ;
  assign epcOut   = epcQ;
  assign causeOut = causeQ;

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !s.irWrite |=> $stable(irQ)); // R2

  AST_OVF_SCOPE: assert property (@(posedge clk) disable iff (!rstN)
    aluOverflow |-> (s.aluOp == AOP_FUNCT) && ((funct == FN_ADD) || (funct == FN_SUB))); // R6

  AST_A_ZERO_REG: assert property (@(posedge clk) disable iff (!rstN)
    (rsF == '0) |=> (aQ == '0)); // R8

  AST_B_ZERO_REG: assert property (@(posedge clk) disable iff (!rstN)
    (rtF == '0) |=> (bQ == '0)); // R8

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(s.pcWrite || (s.pcWriteCond && aluZero)) |=> $stable(pcQ)); // R9

  AST_TRAP_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (s.pcWrite && (s.pcSource == PCS_TRAP)) |=> (pcQ == HANDLER_PC)); // R10

  AST_JUMP_REGION: assert property (@(posedge clk) disable iff (!rstN)
    (s.pcWrite && (s.pcSource == PCS_JUMP)) |=>
      (pcQ[WORD_W-1:WORD_W-4] == $past(pcQ[WORD_W-1:WORD_W-4])) && (pcQ[1:0] == 2'b00)); // R10

  AST_EPC_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !s.epcWrite |=> $stable(epcQ)); // R11

  AST_CAUSE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !s.causeWrite |=> $stable(causeQ)); // R11
endmodule

// File: rtl/multiCycleDatapath.sv
`timescale 1ns/1ps
module multiCycleDatapath
  import mcPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcWrite,
  input  logic              pcWriteCond,
  input  logic              iorD,
  input  logic              irWrite,
  input  logic              regDst,
  input  logic              memToReg,
  input  logic              regWrite,
  input  logic              aluSrcA,
  input  logic [1:0]        aluSrcB,
  input  logic [1:0]        aluOp,
  input  logic [1:0]        pcSource,
  input  logic              epcWrite,
  input  logic              causeWrite,
  input  logic              intCause,
  input  logic [WORD_W-1:0] memRData,
  output logic [WORD_W-1:0] memAddr,
  output logic [WORD_W-1:0] memWData,
  output logic [FN_W-1:0]   opcode,
  output logic [FN_W-1:0]   funct,
  output logic              aluZero,
  output logic              aluOverflow,
  output logic [WORD_W-1:0] epcOut,
  output logic [WORD_W-1:0] causeOut
);
  strobes_t strobes;

  always_comb begin
    strobes.pcWrite     = pcWrite;
    strobes.pcWriteCond = pcWriteCond;
    strobes.iorD        = iorD;
    strobes.irWrite     = irWrite;
    strobes.regDst      = regDst;
    strobes.memToReg    = memToReg;
    strobes.regWrite    = regWrite;
    strobes.aluSrcA     = aluSrcA;
    strobes.aluSrcB     = srcB_e'(aluSrcB);
    strobes.aluOp       = aluOp_e'(aluOp);
    strobes.pcSource    = pcSrc_e'(pcSource);
    strobes.epcWrite    = epcWrite;
    strobes.causeWrite  = causeWrite;
    strobes.intCause    = intCause;
  end

  mcDpCore uCore (
    .clk         (clk),
    .rstN        (rstN),
    .s           (strobes),
    .memRData    (memRData),
    .memAddr     (memAddr),
    .memWData    (memWData),
    .opcode      (opcode),
    .funct       (funct),
    .aluZero     (aluZero),
    .aluOverflow (aluOverflow),
    .epcOut      (epcOut),
    .causeOut    (causeOut)
  );
endmodule

// File: tb/tb_multiCycleDatapath.sv
`timescale 1ns/1ps
module tb_multiCycleDatapath;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN;
  logic pcWrite, pcWriteCond, iorD, irWrite, regDst, memToReg, regWrite, aluSrcA;
  logic [1:0] aluSrcB, aluOp, pcSource;
  logic epcWrite, causeWrite, intCause;
  logic [31:0] memRData, memAddr, memWData, epcOut, causeOut;
  logic [5:0] opcode, funct;
  logic aluZero, aluOverflow;
  logic memWeTb;

  logic [31:0] mem [1024];
  logic [31:0] sr [32];
  logic [31:0] shPc;
  int checks = 0;
  int errors = 0;

  multiCycleDatapath dut (
    .clk(clk), .rstN(rstN), .pcWrite(pcWrite), .pcWriteCond(pcWriteCond),
    .iorD(iorD), .irWrite(irWrite), .regDst(regDst), .memToReg(memToReg),
    .regWrite(regWrite), .aluSrcA(aluSrcA), .aluSrcB(aluSrcB), .aluOp(aluOp),
    .pcSource(pcSource), .epcWrite(epcWrite), .causeWrite(causeWrite),
    .intCause(intCause), .memRData(memRData), .memAddr(memAddr),
    .memWData(memWData), .opcode(opcode), .funct(funct), .aluZero(aluZero),
    .aluOverflow(aluOverflow), .epcOut(epcOut), .causeOut(causeOut)
  );

  assign memRData = mem[memAddr[11:2]];
  always @(posedge clk) if (memWeTb) mem[memAddr[11:2]] <= memWData;

  function automatic logic [31:0] refAlu(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    case (fn)
      6'h20:   return a + b;
      6'h22:   return a - b;
      6'h24:   return a & b;
      6'h25:   return a | b;
      6'h2A:   return ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic refOvf(input logic [5:0] fn, input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    if (fn == 6'h20) begin
      r = a + b;
      return (a[31] == b[31]) && (r[31] != a[31]);
    end
    if (fn == 6'h22) begin
      r = a - b;
      return (a[31] != b[31]) && (r[31] != a[31]);
    end
    return 1'b0;
  endfunction

  function automatic logic [31:0] encR(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
    return {6'h00, rs, rt, rd, 5'h00, fn};
  endfunction

  function automatic logic [31:0] encI(input logic [5:0] op, input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] sext(input logic [15:0] imm);
    return {{16{imm[15]}}, imm};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearCtl();
    pcWrite = 0; pcWriteCond = 0; iorD = 0; irWrite = 0; regDst = 0;
    memToReg = 0; regWrite = 0; aluSrcA = 0; aluSrcB = 2'b00; aluOp = 2'b00;
    pcSource = 2'b00; epcWrite = 0; causeWrite = 0; intCause = 0; memWeTb = 0;
  endtask

  task automatic doFetch(input logic [31:0] instr);
    mem[shPc[11:2]] = instr;
    clearCtl();
    irWrite = 1; pcWrite = 1; aluSrcB = 2'b01;
    #1 chk("R3 fetch address from PC", memAddr, shPc);
    @(negedge clk);
    shPc = shPc + 32'd4;
  endtask

  task automatic doDecode();
    clearCtl();
    aluSrcB = 2'b11;
    @(negedge clk);
  endtask

  task automatic rTail(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
    clearCtl();
    aluSrcA = 1; aluOp = 2'b10;
    #1 chk("R6 overflow flag", {31'b0, aluOverflow}, {31'b0, refOvf(fn, sr[rs], sr[rt])});
    @(negedge clk);
    clearCtl();
    regDst = 1; regWrite = 1;
    @(negedge clk);
    if (rd != 5'd0) sr[rd] = refAlu(fn, sr[rs], sr[rt]);
  endtask

  task automatic doRtype(input logic [4:0] rs, input logic [4:0] rt, input logic [4:0] rd, input logic [5:0] fn);
    doFetch(encR(rs, rt, rd, fn));
    doDecode();
    rTail(rs, rt, rd, fn);
  endtask

  task automatic doLoad(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] imm);
    logic [31:0] ea;
    logic [31:0] val;
    ea = sr[base] + sext(imm);
    doFetch(encI(6'h23, base, rt, imm));
    doDecode();
    clearCtl();
    aluSrcA = 1; aluSrcB = 2'b10;
    @(negedge clk);
    clearCtl();
    iorD = 1;
    val = mem[ea[11:2]];
    #1 chk("R3 load address from ALU result", memAddr, ea);
    @(negedge clk);
    clearCtl();
    memToReg = 1; regWrite = 1;
    @(negedge clk);
    if (rt != 5'd0) sr[rt] = val;
  endtask

  task automatic doStore(input logic [4:0] rt, input logic [4:0] base, input logic [15:0] imm, input string req);
    logic [31:0] ea;
    ea = sr[base] + sext(imm);
    doFetch(encI(6'h2B, base, rt, imm));
    doDecode();
    clearCtl();
    aluSrcA = 1; aluSrcB = 2'b10;
    @(negedge clk);
    clearCtl();
    iorD = 1; memWeTb = 1;
    #1;
    chk(req, memWData, sr[rt]);
    chk("R3 store address from ALU result", memAddr, ea);
    @(negedge clk);
    clearCtl();
  endtask

  task automatic setReg(input logic [4:0] r, input logic [31:0] val);
    mem[10'h240 + 10'(r)] = val;
    doLoad(r, 5'd0, 16'h0900 + 16'(r) * 16'd4);
  endtask

  task automatic doBeq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] imm, input logic taken);
    logic [31:0] base;
    doFetch(encI(6'h04, rs, rt, imm));
    base = shPc;
    doDecode();
    clearCtl();
    aluSrcA = 1; aluOp = 2'b01; pcWriteCond = 1; pcSource = 2'b01;
    #1 chk("R6 zero flag on compare", {31'b0, aluZero}, {31'b0, taken});
    @(negedge clk);
    if (taken) shPc = base + {sext(imm)[29:0], 2'b00};
    clearCtl();
    #1 chk("R9 R4 PC after branch", memAddr, shPc);
  endtask

  task automatic doTrap(input logic cause);
    clearCtl();
    aluSrcB = 2'b01; aluOp = 2'b01; epcWrite = 1; causeWrite = 1; intCause = cause;
    pcWrite = 1; pcSource = 2'b11;
    @(negedge clk);
    clearCtl();
  endtask

  task automatic finish();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    finish();
  end

  initial begin
    logic [4:0] rs, rt, rd;
    logic [5:0] fn;
    logic [31:0] faultPc;
    logic [31:0] tmp;
    int seedInit;
    seedInit = $urandom(32'd97531);
    for (int i = 0; i < 1024; i++) mem[i] = 32'd0;
    for (int i = 0; i < 32; i++) sr[i] = 32'd0;
    clearCtl();
    shPc = 32'd0;
    rstN = 0;
    repeat (2) @(negedge clk);
    chk("R1 reset PC", memAddr, 32'd0);
    chk("R1 reset EPC", epcOut, 32'd0);
    chk("R1 reset Cause", causeOut, 32'd0);
    rstN = 1;
    @(negedge clk);
    chk("R1 PC after release", memAddr, 32'd0);

    // fill all registers through loads (rt destination, regDst=0)
    for (int r = 1; r < 32; r++) begin
      mem[10'h200 + 10'(r)] = $urandom;
      doLoad(5'(r), 5'd0, 16'h0800 + 16'(r) * 16'd4);
    end
    doStore(5'd5, 5'd0, 16'h0A00, "R7 loaded value reaches B");
    doStore(5'd31, 5'd0, 16'h0A04, "R7 loaded value reaches B");

    // register 0 ignores writes from both write paths
    doRtype(5'd1, 5'd2, 5'd0, 6'h25);
    doStore(5'd0, 5'd0, 16'h0A08, "R8 zero register after R-type write");
    mem[10'h2F0] = 32'hDEAD_BEEF;
    doLoad(5'd0, 5'd0, 16'h0BC0);
    doStore(5'd0, 5'd0, 16'h0A0C, "R8 zero register after load write");

    // instruction register hold
    doFetch(encR(5'd1, 5'd2, 5'd9, 6'h24));
    chk("R2 opcode field", {26'b0, opcode}, 32'd0);
    chk("R2 funct field", {26'b0, funct}, 32'h24);
    tmp = shPc - 32'd4;
    mem[tmp[11:2]] = 32'h8C00_0000;
    doDecode();
    chk("R2 IR held without irWrite", {26'b0, funct}, 32'h24);
    chk("R2 IR held opcode", {26'b0, opcode}, 32'd0);
    rTail(5'd1, 5'd2, 5'd9, 6'h24);
    doStore(5'd9, 5'd0, 16'h0A10, "R5 and result");

    // signed set-less-than
    setReg(5'd7, 32'hFFFF_FFFF);
    setReg(5'd8, 32'd1);
    doRtype(5'd7, 5'd8, 5'd10, 6'h2A);
    doStore(5'd10, 5'd0, 16'h0A14, "R5 signed slt negative");
    doRtype(5'd8, 5'd7, 5'd11, 6'h2A);
    doStore(5'd11, 5'd0, 16'h0A18, "R5 signed slt positive");

    // subtract overflow and its flag
    setReg(5'd12, 32'h8000_0000);
    doRtype(5'd12, 5'd8, 5'd13, 6'h22);
    doStore(5'd13, 5'd0, 16'h0A1C, "R5 sub wraps");

    // branches
    setReg(5'd4, 32'h1234_5678);
    setReg(5'd5, 32'h1234_5678);
    setReg(5'd6, 32'h1234_5679);
    doBeq(5'd4, 5'd5, 16'd3, 1'b1);
    doBeq(5'd4, 5'd6, 16'hFFFE, 1'b0);
    doBeq(5'd5, 5'd4, 16'hFFFC, 1'b1);

    // random register arithmetic
    for (int i = 0; i < 40; i++) begin
      rs = 5'($urandom_range(31, 0));
      rt = 5'($urandom_range(31, 0));
      rd = 5'($urandom_range(31, 0));
      case ($urandom_range(4, 0))
        0: fn = 6'h20;
        1: fn = 6'h22;
        2: fn = 6'h24;
        3: fn = 6'h25;
        default: fn = 6'h2A;
      endcase
      doRtype(rs, rt, rd, fn);
      doStore(rd, 5'd0, 16'h0C00 + 16'(i) * 16'd4, "R5 random result");
    end

    // overflow trap: EPC capture and redirect in one cycle
    setReg(5'd1, 32'h7FFF_FFFF);
    setReg(5'd2, 32'd1);
    faultPc = shPc;
    doFetch(encR(5'd1, 5'd2, 5'd3, 6'h20));
    doDecode();
    clearCtl();
    aluSrcA = 1; aluOp = 2'b10;
    #1 chk("R6 add overflow flagged", {31'b0, aluOverflow}, 32'd1);
    @(negedge clk);
    doTrap(1'b1);
    shPc = 32'h8000_0180;
    chk("R11 EPC holds faulting address", epcOut, faultPc);
    chk("R11 Cause overflow code", causeOut, 32'd1);
    chk("R10 trap entry address", memAddr, 32'h8000_0180);

    // jump keeps the upper PC bits
    doFetch({6'h02, 26'h000_0100});
    doDecode();
    clearCtl();
    pcWrite = 1; pcSource = 2'b10;
    @(negedge clk);
    clearCtl();
    shPc = 32'h8000_0400;
    #1 chk("R10 jump target", memAddr, 32'h8000_0400);
    chk("R11 EPC held without enable", epcOut, faultPc);
    chk("R11 Cause held without enable", causeOut, 32'd1);

    // undefined instruction trap
    faultPc = shPc;
    doFetch(32'hFC00_0000);
    chk("R2 undefined opcode field", {26'b0, opcode}, 32'h3F);
    doDecode();
    doTrap(1'b0);
    shPc = 32'h8000_0180;
    chk("R11 Cause undefined code", causeOut, 32'd0);
    chk("R11 EPC second trap", epcOut, faultPc);
    chk("R10 trap entry again", memAddr, 32'h8000_0180);

    finish();
  end
endmodule